// File: doc/BRIEF.md
# Dual-Path Frame Buffer with Serial Row Output

This block holds a one-bit-per-pixel frame image in a square array of storage words and reaches it from two sides. A host-side random path updates single bits at any row and column, or paints an axis-aligned rectangle to all zeros or all ones. The rectangle engine handles one row per cycle and blocks the host path while it runs. Malformed rectangles are refused.

A video-side path requests that a whole row be copied into a shift register in one cycle. The shift register then feeds pixels out one per shift request, starting at column 0. This path works independently of the host path. A row copy is refused only in a cycle where a write lands on that same row. Shifting past the last pixel without a fresh row raises a one-cycle underflow flag.

Top module: `fbm_top`

## Requirements
- R1: When `wr_valid_i` and `wr_ready_o` are both high at a clock edge, the bit at (`wr_row_i`, `wr_col_i`) takes `wr_bit_i` from the next cycle. Every other bit is unchanged.
- R2: A fill offered while `fill_busy_o` is low with `fill_row_lo_i <= fill_row_hi_i` and `fill_col_lo_i <= fill_col_hi_i` sets every bit in those rows and columns (bounds inclusive) to `fill_value_i`. No bit outside the rectangle changes.
- R3: After an accepted valid fill, `fill_busy_o` is high from the next cycle for exactly `row_hi - row_lo + 1` cycles. `wr_ready_o` is the inverse of `fill_busy_o`. Bit writes and fills offered while busy are ignored.
- R4: A fill offered while idle with `row_lo > row_hi` or `col_lo > col_hi` raises `fill_err_o` for exactly the next cycle. It leaves `fill_busy_o` low and does not change memory.
- R5: `xfer_ok_o` is high combinationally when `xfer_req_i` is high and no write to row `xfer_row_i` occurs in that cycle. After an accepted copy, the shift register holds that row's pre-edge contents and `pix_valid_o` is high from the next cycle.
- R6: If a bit write or fill row write targets `xfer_row_i` in the same cycle as `xfer_req_i`, `xfer_ok_o` is low and the shift register and `pix_valid_o` are unchanged.
- R7: `pix_o` shows column 0 of the loaded row first. Each `shift_i` advances to the next higher column. After as many shifts as there are columns, `pix_valid_o` is low.
- R8: `shift_i` with `pix_valid_o` low and no accepted copy raises `underflow_o` for the next cycle only. A shift with `pix_valid_o` high raises no underflow.
- R9: When a copy is accepted in the same cycle as `shift_i`, the copy wins. The new row starts at column 0 and that shift has no effect.
- R10: While `rst_ni` is low, `fill_busy_o`, `fill_err_o`, `pix_valid_o`, `underflow_o` and `pix_o` are 0 and `wr_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Bit write request |
| wr_row_i | input | $clog2(ROWS) | Bit write row |
| wr_col_i | input | $clog2(COLS) | Bit write column |
| wr_bit_i | input | 1 | Bit write value |
| wr_ready_o | output | 1 | Bit write accepted when high |
| fill_valid_i | input | 1 | Rectangle fill request |
| fill_row_lo_i | input | $clog2(ROWS) | First row of rectangle |
| fill_row_hi_i | input | $clog2(ROWS) | Last row of rectangle |
| fill_col_lo_i | input | $clog2(COLS) | First column of rectangle |
| fill_col_hi_i | input | $clog2(COLS) | Last column of rectangle |
| fill_value_i | input | 1 | Fill value |
| fill_busy_o | output | 1 | Fill in progress |
| fill_err_o | output | 1 | Malformed fill refused, one-cycle pulse |
| xfer_req_i | input | 1 | Row copy request |
| xfer_row_i | input | $clog2(ROWS) | Row to copy |
| xfer_ok_o | output | 1 | Row copy accepted this cycle |
| shift_i | input | 1 | Advance serial output |
| pix_o | output | 1 | Current serial pixel |
| pix_valid_o | output | 1 | Unsent pixels remain |
| underflow_o | output | 1 | Shift after last pixel, one-cycle pulse |

## Verification
The bench builds the block with 8 rows of 16 columns. At that size every row can be read back through the serial path after every operation and compared whole against a bench model.

This size lets the bench sweep all 128 bit addresses and a series of arithmetically generated rectangles. The series includes full-width, single-row and single-column cases. Because `row_hi - row_lo + 1` is at most 8, the bench can count every busy window exactly. The row-copy collision, the copy-over-shift priority and the underflow edge are each placed on chosen cycles.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  typedef enum logic {FILL_IDLE, FILL_RUN} fill_state_e;
endpackage

// File: rtl/fbm_array.sv
module fbm_array #(
  parameter int ROWS = 256,
  parameter int COLS = 256,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [RW-1:0]   wrow_i,
  input  logic [COLS-1:0] wmask_i,
  input  logic [COLS-1:0] wdata_i,
  input  logic [RW-1:0]   rrow_i,
  output logic [COLS-1:0] rdata_o
);
  logic [COLS-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wrow_i] <= (mem_q[wrow_i] & ~wmask_i) | (wdata_i & wmask_i);
  end

  assign rdata_o = mem_q[rrow_i];
endmodule

// File: rtl/fbm_fill.sv
module fbm_fill
  import fbm_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int COLS = 256,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [RW-1:0]   row_lo_i,
  input  logic [RW-1:0]   row_hi_i,
  input  logic [CW-1:0]   col_lo_i,
  input  logic [CW-1:0]   col_hi_i,
  input  logic            value_i,
  output logic            busy_o,
  output logic            err_o,
  output logic            wr_en_o,
  output logic [RW-1:0]   wr_row_o,
  output logic [COLS-1:0] wr_mask_o,
  output logic [COLS-1:0] wr_data_o
);
  fill_state_e     st_q;
  logic [RW-1:0]   cur_q, end_q;
  logic [COLS-1:0] mask_q, mask_d;
  logic            value_q, err_q;
  logic            accept, bad;

  for (genvar i = 0; i < COLS; i++) begin : g_mask
    assign mask_d[i] = (CW'(i) >= col_lo_i) && (CW'(i) <= col_hi_i);
  end

  assign accept = cmd_valid_i && (st_q == FILL_IDLE);
  assign bad    = (row_lo_i > row_hi_i) || (col_lo_i > col_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FILL_IDLE;
      cur_q   <= '0;
      end_q   <= '0;
      mask_q  <= '0;
      value_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && bad;
      case (st_q)
        FILL_IDLE: if (accept && !bad) begin
          st_q    <= FILL_RUN;
          cur_q   <= row_lo_i;
          end_q   <= row_hi_i;
          mask_q  <= mask_d;
          value_q <= value_i;
        end
        FILL_RUN: begin
          if (cur_q == end_q) st_q <= FILL_IDLE;
          else cur_q <= cur_q + 1'b1;
        end
        default: st_q <= FILL_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q == FILL_RUN);
  assign err_o     = err_q;
  assign wr_en_o   = (st_q == FILL_RUN);
  assign wr_row_o  = cur_q;
  assign wr_mask_o = mask_q;
  assign wr_data_o = {COLS{value_q}};
endmodule

// File: rtl/fbm_shifter.sv
module fbm_shifter #(
  parameter int COLS = 256,
  localparam int NW = $clog2(COLS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [COLS-1:0] data_i,
  input  logic            shift_i,
  output logic            pix_o,
  output logic            valid_o,
  output logic            underflow_o
);
  logic [COLS-1:0] sr_q;
  logic [NW-1:0]   left_q;
  logic            udf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      udf_q  <= 1'b0;
    end else begin
      udf_q <= shift_i && !load_i && (left_q == '0);
      if (load_i) begin
        sr_q   <= data_i;
        left_q <= NW'(COLS);
      end else if (shift_i && left_q != '0) begin
        sr_q   <= sr_q >> 1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign pix_o       = sr_q[0];
  assign valid_o     = (left_q != '0);
  assign underflow_o = udf_q;
endmodule

// File: rtl/fbm_top.sv
module fbm_top #(
  parameter int ROWS = 256,
  parameter int COLS = 256,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [RW-1:0] wr_row_i,
  input  logic [CW-1:0] wr_col_i,
  input  logic          wr_bit_i,
  output logic          wr_ready_o,
  input  logic          fill_valid_i,
  input  logic [RW-1:0] fill_row_lo_i,
  input  logic [RW-1:0] fill_row_hi_i,
  input  logic [CW-1:0] fill_col_lo_i,
  input  logic [CW-1:0] fill_col_hi_i,
  input  logic          fill_value_i,
  output logic          fill_busy_o,
  output logic          fill_err_o,
  input  logic          xfer_req_i,
  input  logic [RW-1:0] xfer_row_i,
  output logic          xfer_ok_o,
  input  logic          shift_i,
  output logic          pix_o,
  output logic          pix_valid_o,
  output logic          underflow_o
);
  logic            f_we;
  logic [RW-1:0]   f_row;
  logic [COLS-1:0] f_mask, f_data;
  logic            b_we, we;
  logic [RW-1:0]   wrow;
  logic [COLS-1:0] wmask, wdata, rdata;

  fbm_fill #(.ROWS(ROWS), .COLS(COLS)) u_fill (
    .clk_i, .rst_ni,
    .cmd_valid_i(fill_valid_i),
    .row_lo_i(fill_row_lo_i), .row_hi_i(fill_row_hi_i),
    .col_lo_i(fill_col_lo_i), .col_hi_i(fill_col_hi_i),
    .value_i(fill_value_i),
    .busy_o(fill_busy_o), .err_o(fill_err_o),
    .wr_en_o(f_we), .wr_row_o(f_row), .wr_mask_o(f_mask), .wr_data_o(f_data)
  );

  // host bit writes stall while a fill owns the write port
  assign wr_ready_o = !fill_busy_o;
  assign b_we  = wr_valid_i && wr_ready_o;
  assign we    = f_we || b_we;
  assign wrow  = f_we ? f_row  : wr_row_i;
  assign wmask = f_we ? f_mask : (COLS'(1) << wr_col_i);
  assign wdata = f_we ? f_data : {COLS{wr_bit_i}};

  assign xfer_ok_o = xfer_req_i && !(we && (wrow == xfer_row_i));

  fbm_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk_i, .we_i(we), .wrow_i(wrow), .wmask_i(wmask), .wdata_i(wdata),
    .rrow_i(xfer_row_i), .rdata_o(rdata)
  );

  fbm_shifter #(.COLS(COLS)) u_shift (
    .clk_i, .rst_ni,
    .load_i(xfer_ok_o), .data_i(rdata), .shift_i(shift_i),
    .pix_o(pix_o), .valid_o(pix_valid_o), .underflow_o(underflow_o)
  );
endmodule

// File: rtl/fbm_top_chk.sv
module fbm_top_chk #(
  parameter int ROWS = 256,
  parameter int COLS = 256,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic [RW-1:0] wr_row_i,
  input logic          wr_ready_o,
  input logic          fill_valid_i,
  input logic [RW-1:0] fill_row_lo_i,
  input logic [RW-1:0] fill_row_hi_i,
  input logic [CW-1:0] fill_col_lo_i,
  input logic [CW-1:0] fill_col_hi_i,
  input logic          fill_busy_o,
  input logic          fill_err_o,
  input logic          xfer_req_i,
  input logic [RW-1:0] xfer_row_i,
  input logic          xfer_ok_o,
  input logic          shift_i,
  input logic          pix_o,
  input logic          pix_valid_o,
  input logic          underflow_o
);
  p_fill_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_busy_o && fill_row_lo_i <= fill_row_hi_i &&
     fill_col_lo_i <= fill_col_hi_i) |=> fill_busy_o);

  p_bad_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_busy_o && fill_row_lo_i > fill_row_hi_i)
      |=> (fill_err_o && !fill_busy_o));

  p_err_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> !fill_busy_o);

  p_load_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ok_o |=> pix_valid_o);

  p_collide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_i && wr_valid_i && wr_ready_o && wr_row_i == xfer_row_i) |-> !xfer_ok_o);

  p_pix_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !xfer_ok_o) |=> ($stable(pix_o) && $stable(pix_valid_o)));

  p_udf_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> ($past(shift_i) && !$past(pix_valid_o) && !$past(xfer_ok_o)));
endmodule

bind fbm_top fbm_top_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk_i, .rst_ni, .wr_valid_i, .wr_row_i, .wr_ready_o, .fill_valid_i,
  .fill_row_lo_i, .fill_row_hi_i, .fill_col_lo_i, .fill_col_hi_i,
  .fill_busy_o, .fill_err_o, .xfer_req_i, .xfer_row_i, .xfer_ok_o,
  .shift_i, .pix_o, .pix_valid_o, .underflow_o
);

// File: tb/fbm_top_tb.sv
module fbm_top_tb;
  localparam int ROWS = 8;
  localparam int COLS = 16;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 0, wr_bit_i = 0, wr_ready_o;
  logic [RW-1:0] wr_row_i = '0;
  logic [CW-1:0] wr_col_i = '0;
  logic fill_valid_i = 0, fill_value_i = 0, fill_busy_o, fill_err_o;
  logic [RW-1:0] fill_row_lo_i = '0, fill_row_hi_i = '0;
  logic [CW-1:0] fill_col_lo_i = '0, fill_col_hi_i = '0;
  logic xfer_req_i = 0, xfer_ok_o, shift_i = 0, pix_o, pix_valid_o, underflow_o;
  logic [RW-1:0] xfer_row_i = '0;

  logic [COLS-1:0] mdl [ROWS];
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fbm_top #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk_i(clk), .rst_ni, .wr_valid_i, .wr_row_i, .wr_col_i, .wr_bit_i, .wr_ready_o,
    .fill_valid_i, .fill_row_lo_i, .fill_row_hi_i, .fill_col_lo_i, .fill_col_hi_i,
    .fill_value_i, .fill_busy_o, .fill_err_o, .xfer_req_i, .xfer_row_i, .xfer_ok_o,
    .shift_i, .pix_o, .pix_valid_o, .underflow_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // collect COLS pixels from the shift register, starting at current negedge
  task automatic collect(output logic [COLS-1:0] w, output bit vld_ok);
    vld_ok = 1;
    for (int i = 0; i < COLS; i++) begin
      if (!pix_valid_o) vld_ok = 0;
      w[i] = pix_o;
      shift_i = 1;
      @(negedge clk);
    end
    shift_i = 0;
  endtask

  task automatic read_row(input int r, output logic [COLS-1:0] w);
    bit v;
    xfer_req_i = 1; xfer_row_i = RW'(r);
    @(negedge clk);
    xfer_req_i = 0;
    collect(w, v);
    chk(v, "R7", "pix_valid during row", 64'(v), 64'd1);
    chk(!pix_valid_o, "R7", "pix_valid after last", 64'(pix_valid_o), 64'd0);
  endtask

  task automatic check_all(input string req);
    logic [COLS-1:0] w;
    for (int r = 0; r < ROWS; r++) begin
      read_row(r, w);
      chk(w == mdl[r], req, $sformatf("row %0d", r), 64'(w), 64'(mdl[r]));
    end
  endtask

  task automatic do_fill(input int r0, input int r1, input int c0, input int c1, input bit v);
    int cnt = 0;
    bit bad = (r0 > r1) || (c0 > c1);
    fill_valid_i = 1; fill_row_lo_i = RW'(r0); fill_row_hi_i = RW'(r1);
    fill_col_lo_i = CW'(c0); fill_col_hi_i = CW'(c1); fill_value_i = v;
    @(negedge clk);
    fill_valid_i = 0;
    if (bad) begin
      chk(fill_err_o == 1 && fill_busy_o == 0, "R4", "err pulse/busy", {fill_err_o, fill_busy_o}, 64'h2);
      @(negedge clk);
      chk(fill_err_o == 0, "R4", "err one cycle", 64'(fill_err_o), 64'd0);
    end else begin
      chk(fill_err_o == 0, "R2", "no err on valid fill", 64'(fill_err_o), 64'd0);
      while (fill_busy_o && cnt < 100) begin
        if (wr_ready_o) begin
          chk(0, "R3", "ready while busy", 64'(wr_ready_o), 64'd0);
        end
        cnt++;
        @(negedge clk);
      end
      chk(cnt == r1 - r0 + 1, "R3", "busy length", 64'(cnt), 64'(r1 - r0 + 1));
      for (int r = r0; r <= r1; r++)
        for (int c = c0; c <= c1; c++) mdl[r][c] = v;
    end
  endtask

  task automatic bit_write(input int r, input int c, input bit b);
    wr_valid_i = 1; wr_row_i = RW'(r); wr_col_i = CW'(c); wr_bit_i = b;
    @(negedge clk);
    wr_valid_i = 0;
    mdl[r][c] = b;
  endtask

  initial begin
    logic [COLS-1:0] w;
    bit v;
    @(negedge clk);
    // R10: reset state
    chk({fill_busy_o, fill_err_o, pix_valid_o, underflow_o, pix_o} == 0 && wr_ready_o,
        "R10", "reset outputs", {fill_busy_o, fill_err_o, pix_valid_o, underflow_o, pix_o, wr_ready_o}, 64'h1);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R2/R3: clear whole array, then sweep of rectangles
    do_fill(0, ROWS-1, 0, COLS-1, 0);
    check_all("R2");
    for (int k = 0; k < 14; k++) begin
      int r0 = k % ROWS;
      int r1 = r0 + (k * 3) % (ROWS - r0);
      int c0 = (k * 5) % COLS;
      int c1 = c0 + (k * 7) % (COLS - c0);
      do_fill(r0, r1, c0, c1, k[0] ^ k[2]);
      check_all("R2");
    end

    // R1: every address written with a pattern
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) bit_write(r, c, ((r * 3 + c + r * c) % 3) == 0);
    check_all("R1");

    // R4: malformed fills leave memory unchanged
    do_fill(5, 2, 0, 3, 1);
    do_fill(1, 1, 9, 4, 1);
    do_fill(6, 0, 15, 0, 0);
    check_all("R4");

    // R3: writes and fills offered while busy are ignored
    fill_valid_i = 1; fill_row_lo_i = 0; fill_row_hi_i = RW'(ROWS-1);
    fill_col_lo_i = 0; fill_col_hi_i = CW'(COLS-1); fill_value_i = 1;
    @(negedge clk);
    wr_valid_i = 1; wr_row_i = 0; wr_col_i = 0; wr_bit_i = 0;
    fill_row_lo_i = 2; fill_row_hi_i = 2; fill_col_lo_i = 0; fill_col_hi_i = 0; fill_value_i = 0;
    #1 chk(fill_busy_o && !wr_ready_o, "R3", "busy stalls writes", {fill_busy_o, wr_ready_o}, 64'h2);
    @(negedge clk);
    wr_valid_i = 0; fill_valid_i = 0;
    while (fill_busy_o) @(negedge clk);
    for (int r = 0; r < ROWS; r++) mdl[r] = '1;
    check_all("R3");

    // restore distinct row pattern
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) bit_write(r, c, ((r + 2 * c) % 5) < 2);

    // R8: shift on empty register
    chk(!pix_valid_o, "R8", "empty before", 64'(pix_valid_o), 64'd0);
    shift_i = 1;
    @(negedge clk);
    shift_i = 0;
    chk(underflow_o == 1, "R8", "underflow raised", 64'(underflow_o), 64'd1);
    @(negedge clk);
    chk(underflow_o == 0, "R8", "underflow one cycle", 64'(underflow_o), 64'd0);

    // R6: collision with same-row write
    wr_valid_i = 1; wr_row_i = 3; wr_col_i = 5; wr_bit_i = ~mdl[3][5];
    xfer_req_i = 1; xfer_row_i = 3;
    #1 chk(xfer_ok_o == 0, "R6", "copy refused", 64'(xfer_ok_o), 64'd0);
    @(negedge clk);
    wr_valid_i = 0; xfer_req_i = 0;
    mdl[3][5] = ~mdl[3][5];
    chk(!pix_valid_o, "R6", "shifter untouched", 64'(pix_valid_o), 64'd0);

    // R5: different-row write, copy accepted with pre-edge data
    wr_valid_i = 1; wr_row_i = 4; wr_col_i = 0; wr_bit_i = ~mdl[4][0];
    xfer_req_i = 1; xfer_row_i = 5;
    #1 chk(xfer_ok_o == 1, "R5", "copy accepted", 64'(xfer_ok_o), 64'd1);
    @(negedge clk);
    wr_valid_i = 0; xfer_req_i = 0;
    mdl[4][0] = ~mdl[4][0];
    chk(pix_valid_o && pix_o == mdl[5][0], "R5", "row loaded", {pix_valid_o, pix_o}, {1'b1, mdl[5][0]});
    collect(w, v);
    chk(w == mdl[5] && v, "R5", "row 5 contents", 64'(w), 64'(mdl[5]));
    // R8: shift with valid data raised no underflow; last shift above left register empty
    chk(underflow_o == 0, "R8", "no underflow on valid shifts", 64'(underflow_o), 64'd0);

    // R9: load wins over concurrent shift
    xfer_req_i = 1; xfer_row_i = 1;
    @(negedge clk);
    xfer_req_i = 0;
    for (int i = 0; i < 3; i++) begin shift_i = 1; @(negedge clk); end
    shift_i = 0;
    chk(pix_o == mdl[1][3], "R7", "column 3 after three shifts", 64'(pix_o), 64'(mdl[1][3]));
    xfer_req_i = 1; xfer_row_i = 2; shift_i = 1;
    @(negedge clk);
    xfer_req_i = 0; shift_i = 0;
    chk(underflow_o == 0, "R9", "no underflow", 64'(underflow_o), 64'd0);
    collect(w, v);
    chk(w == mdl[2] && v, "R9", "new row from column 0", 64'(w), 64'(mdl[2]));

    check_all("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule